// File: doc/BRIEF.md
# Aging Reference-History Victim Selector

This block keeps a small per-frame usage record for a fixed pool of physical memory frames and names a frame to give up when a new page has to be placed. Every frame carries a one-bit "touched" flag and an 11-bit history word. A reference strobe marks a frame as touched. A timebase strobe drives the aging, and after a fixed number of these strobes every frame's history takes in its touched flag at the top bit while the older bits move one place toward the bottom. The touched flag is then cleared so that the next interval starts empty.

When page-replacement logic needs a frame it raises a request with a ranking mode. Recency mode treats each history as an unsigned number and picks the smallest, so the victim is the frame that has gone unused for the longest time. Frequency mode picks the history with the fewest set bits, so the victim is the frame used least often in the recorded window. The scan visits one frame per cycle and then presents the result with a one-cycle valid strobe. A load strobe clears a frame's record when a new page is installed in it.

Top module: `aging_victim_sel`

## Requirements
- R1: A cycle with `ref_valid` high sets the touched flag of frame `ref_idx`, and the next aging step records it as a 1 in that frame's history top bit.
- R2: On an aging step each frame's history becomes {touched flag, history[HIST_W-1:1]}: the flag enters the top bit, the other bits move right by one and bit 0 is lost.
- R3: The touched flag of every frame is cleared by an aging step unless that same frame is referenced in that cycle.
- R4: An aging step happens on every AGE_INTERVAL-th cycle with `tick` high, counted from reset; the other tick strobes change no history.
- R5: With `req_mode` = 0 (recency) the victim is the frame whose history, read as an unsigned number, is smallest.
- R6: With `req_mode` = 1 (frequency) the victim is the frame whose history holds the fewest 1 bits.
- R7: When several frames share the best rank, the lowest frame index is chosen.
- R8: A request accepted while idle raises `busy` in the next cycle; `victim_valid` is high for exactly one cycle, NUM_FRAMES cycles after the acceptance edge, with `busy` falling at the same edge. The ranking uses the histories as they stand at the acceptance edge, and `victim_idx` holds its value between results.
- R9: A request made while `busy` is high is ignored: it neither restarts the scan nor changes the result or its timing.
- R10: A reference in the same cycle as an aging step belongs to the new interval: the history takes in the old flag and the flag ends up set.
- R11: `load_valid` clears the history and touched flag of frame `load_idx`; it wins over a reference or an aging step to the same frame in the same cycle.
- R12: After reset all histories and flags are zero, the aging count is zero, `busy` and `victim_valid` are low and `victim_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Frame reference strobe |
| ref_idx | input | IDX_W | Frame referenced |
| load_valid | input | 1 | New page installed strobe |
| load_idx | input | IDX_W | Frame being loaded |
| tick | input | 1 | Timebase strobe counted toward aging |
| req_valid | input | 1 | Victim request |
| req_mode | input | 1 | 0 = recency ranking, 1 = frequency ranking |
| busy | output | 1 | Scan in progress, requests ignored |
| victim_valid | output | 1 | One-cycle strobe: victim_idx is new |
| victim_idx | output | IDX_W | Chosen frame |

## Verification
A history bit lost, doubled or shifted the wrong way stays hidden until the next victim request, and the fault shows only if that frame's rank moves across a neighbour's, so the bench asks for a victim after short bursts of activity in both modes, where each frame's record differs from the others by only one or two aging steps. A wrong aging count shows after AGE_INTERVAL tick strobes as a victim chosen too early or too late. A scan-control fault shows within NUM_FRAMES+1 cycles as a strobe arriving at the wrong time, a second strobe, or an index that drifts between results. Activity that continues during a scan makes a missing snapshot show as a changed choice.

// File: rtl/aging_pkg.sv
package aging_pkg;
  // ranking used by the victim scan
  typedef enum logic {
    RANK_RECENCY   = 1'b0,
    RANK_FREQUENCY = 1'b1
  } rank_mode_e;
endpackage

// File: rtl/aging_tick_div.sv
module aging_tick_div #(
  parameter int AGE_INTERVAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic age_pulse
);
  localparam int CNT_W = (AGE_INTERVAL > 1) ? $clog2(AGE_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(AGE_INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;

  assign age_pulse = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (age_pulse) cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/aging_frame_bank.sv
module aging_frame_bank #(
  parameter int NUM_FRAMES = 8,
  parameter int HIST_W     = 11,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ref_valid,
  input  logic [IDX_W-1:0]             ref_idx,
  input  logic                         load_valid,
  input  logic [IDX_W-1:0]             load_idx,
  input  logic                         age_pulse,
  output logic [NUM_FRAMES*HIST_W-1:0] hist_flat
);
  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    logic              touched_q;
    logic [HIST_W-1:0] hist_q;
    logic              ref_hit;
    logic              load_hit;

    assign ref_hit  = ref_valid  && (ref_idx  == IDX_W'(f));
    assign load_hit = load_valid && (load_idx == IDX_W'(f));
    assign hist_flat[f*HIST_W +: HIST_W] = hist_q;

    always_ff @(posedge clk) begin
      if (!rst_n || load_hit) begin
        touched_q <= 1'b0;
        hist_q    <= '0;
      end else begin
        if (age_pulse) hist_q <= {touched_q, hist_q[HIST_W-1:1]};
        // a same-cycle reference lands in the new interval
        if (ref_hit)        touched_q <= 1'b1;
        else if (age_pulse) touched_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aging_victim_scan.sv
module aging_victim_scan #(
  parameter int NUM_FRAMES = 8,
  parameter int HIST_W     = 11,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_mode,
  input  logic [NUM_FRAMES*HIST_W-1:0] hist_flat,
  output logic                         scan_start,
  output logic                         busy,
  output logic                         victim_valid,
  output logic [IDX_W-1:0]             victim_idx
);
  import aging_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  function automatic logic [HIST_W-1:0] ones_of(input logic [HIST_W-1:0] h);
    logic [HIST_W-1:0] n;
    n = '0;
    for (int b = 0; b < HIST_W; b++) n = n + HIST_W'(h[b]);
    return n;
  endfunction

  function automatic logic [HIST_W-1:0] rank_of(input logic [HIST_W-1:0] h,
                                                input rank_mode_e m);
    return (m == RANK_FREQUENCY) ? ones_of(h) : h;
  endfunction

  logic [HIST_W-1:0] snap_q [NUM_FRAMES];
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  best_idx_q;
  logic [HIST_W:0]   best_key_q;
  rank_mode_e        mode_q;
  logic              busy_q;
  logic              valid_q;
  logic [IDX_W-1:0]  victim_q;

  logic [HIST_W:0]   cur_key;
  logic              better;
  logic              last_step;

  assign scan_start = req_valid && !busy_q;
  assign cur_key    = {1'b0, rank_of(snap_q[idx_q], mode_q)};
  assign better     = cur_key < best_key_q;   // strict: lower index keeps ties
  assign last_step  = busy_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FRAMES; f++) snap_q[f] <= '0;
      idx_q      <= '0;
      best_idx_q <= '0;
      best_key_q <= '0;
      mode_q     <= RANK_RECENCY;
      busy_q     <= 1'b0;
      valid_q    <= 1'b0;
      victim_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (scan_start) begin
        for (int f = 0; f < NUM_FRAMES; f++) snap_q[f] <= hist_flat[f*HIST_W +: HIST_W];
        idx_q      <= '0;
        best_key_q <= {1'b1, {HIST_W{1'b0}}};
        mode_q     <= rank_mode_e'(req_mode);
        busy_q     <= 1'b1;
      end else if (busy_q) begin
        if (better) begin
          best_key_q <= cur_key;
          best_idx_q <= idx_q;
        end
        idx_q <= idx_q + 1'b1;
        if (last_step) begin
          busy_q   <= 1'b0;
          valid_q  <= 1'b1;
          victim_q <= better ? idx_q : best_idx_q;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign victim_valid = valid_q;
  assign victim_idx   = victim_q;
endmodule

// File: rtl/aging_victim_sel.sv
module aging_victim_sel #(
  parameter int NUM_FRAMES   = 8,
  parameter int HIST_W       = 11,
  parameter int AGE_INTERVAL = 2,
  localparam int IDX_W       = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             load_valid,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             tick,
  input  logic             req_valid,
  input  logic             req_mode,
  output logic             busy,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_idx
);
  logic                         age_pulse;
  logic                         scan_start;
  logic [NUM_FRAMES*HIST_W-1:0] hist_flat;

  aging_tick_div #(.AGE_INTERVAL(AGE_INTERVAL)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .age_pulse(age_pulse)
  );

  aging_frame_bank #(.NUM_FRAMES(NUM_FRAMES), .HIST_W(HIST_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_idx(ref_idx),
    .load_valid(load_valid), .load_idx(load_idx),
    .age_pulse(age_pulse), .hist_flat(hist_flat)
  );

  aging_victim_scan #(.NUM_FRAMES(NUM_FRAMES), .HIST_W(HIST_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_mode(req_mode), .hist_flat(hist_flat),
    .scan_start(scan_start), .busy(busy),
    .victim_valid(victim_valid), .victim_idx(victim_idx)
  );
endmodule

// File: rtl/aging_victim_chk.sv
module aging_victim_chk #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             req_valid,
  input logic             age_pulse,
  input logic             scan_start,
  input logic             busy,
  input logic             victim_valid,
  input logic [IDX_W-1:0] victim_idx
);
  localparam int CW = $clog2(NUM_FRAMES + 2);
  logic [CW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_run <= '0;
    else                 busy_run <= busy_run + 1'b1;
  end

  // R4
  age_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_pulse |-> tick);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> busy);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  // R8
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (!busy && $past(busy)));

  // R8
  scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= CW'(NUM_FRAMES));

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_valid |-> $stable(victim_idx));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |-> !scan_start);
endmodule

bind aging_victim_sel aging_victim_chk #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
  .age_pulse(age_pulse), .scan_start(scan_start), .busy(busy),
  .victim_valid(victim_valid), .victim_idx(victim_idx)
);

// File: tb/aging_victim_sel_test.sv
module aging_victim_sel_test;
  localparam int CLK_P = 10;
  localparam int NF    = 8;
  localparam int HW    = 11;
  localparam int AI    = 2;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0, load_valid = 1'b0, tick = 1'b0;
  logic          req_valid = 1'b0, req_mode = 1'b0;
  logic [IW-1:0] ref_idx = '0, load_idx = '0;
  logic          busy, victim_valid;
  logic [IW-1:0] victim_idx;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [HW-1:0] m_hist [NF];
  bit            m_ref  [NF];
  int            m_tcnt;

  always #(CLK_P/2) clk = ~clk;

  aging_victim_sel #(.NUM_FRAMES(NF), .HIST_W(HW), .AGE_INTERVAL(AI)) uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .load_valid(load_valid), .load_idx(load_idx), .tick(tick),
    .req_valid(req_valid), .req_mode(req_mode), .busy(busy),
    .victim_valid(victim_valid), .victim_idx(victim_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int bits_set(input logic [HW-1:0] h);
    int n = 0;
    logic [HW-1:0] t = h;
    while (t != 0) begin
      t = t & (t - 1);
      n++;
    end
    return n;
  endfunction

  function automatic int expect_victim(input bit freq, input logic [HW-1:0] s [NF]);
    int best = 0;
    for (int f = 1; f < NF; f++) begin
      int kf = freq ? bits_set(s[f])    : int'(s[f]);
      int kb = freq ? bits_set(s[best]) : int'(s[best]);
      if (kf < kb) best = f;
    end
    return best;
  endfunction

  // one clock: drive at negedge, update model at posedge, return at next negedge
  task automatic cyc(input bit rv, input int ri, input bit lv, input int li,
                     input bit tk, input bit qv, input bit qm);
    bit age;
    ref_valid = rv; ref_idx = IW'(ri); load_valid = lv; load_idx = IW'(li);
    tick = tk; req_valid = qv; req_mode = qm;
    @(posedge clk);
    age = tk && (m_tcnt == AI - 1);
    for (int f = 0; f < NF; f++) begin
      if (lv && li == f) begin
        m_hist[f] = '0;
        m_ref[f]  = 0;
      end else begin
        if (age) m_hist[f] = {m_ref[f], m_hist[f][HW-1:1]};
        if (rv && ri == f) m_ref[f] = 1;
        else if (age)      m_ref[f] = 0;
      end
    end
    if (age)     m_tcnt = 0;
    else if (tk) m_tcnt = m_tcnt + 1;
    @(negedge clk);
    ref_valid = 0; load_valid = 0; tick = 0; req_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ref_frame(input int f);
    cyc(1, f, 0, 0, 0, 0, 0);
  endtask

  task automatic age_once();
    for (int i = 0; i < AI; i++) cyc(0, 0, 0, 0, 1, 0, 0);
  endtask

  // request, keep the bench busy meanwhile, check timing and result
  task automatic ask(input bit mode, input bit noisy, input string tag);
    logic [HW-1:0] snap [NF];
    int exp_v;
    int prev_idx;
    for (int f = 0; f < NF; f++) snap[f] = m_hist[f];
    exp_v    = expect_victim(mode, snap);
    prev_idx = int'(victim_idx);
    cyc(0, 0, 0, 0, 0, 1, mode);
    chk(busy === 1'b1, {tag, " R8 busy after accept"}, int'(busy), 1);
    for (int k = 1; k <= NF; k++) begin
      if (noisy)
        cyc($urandom_range(1, 0) == 1, $urandom_range(NF-1, 0),
            $urandom_range(7, 0) == 0, $urandom_range(NF-1, 0),
            $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, ~mode);
      else
        cyc(0, 0, 0, 0, 0, 0, 0);
      if (k < NF) begin
        if (victim_valid !== 1'b0 || int'(victim_idx) != prev_idx)
          chk(0, {tag, " R8/R9 early or moved result"}, int'(victim_valid), 0);
      end
    end
    chk(victim_valid === 1'b1, {tag, " R8 valid timing"}, int'(victim_valid), 1);
    chk(busy === 1'b0, {tag, " R8 busy falls"}, int'(busy), 0);
    chk(int'(victim_idx) == exp_v, {tag, " victim"}, int'(victim_idx), exp_v);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(victim_valid === 1'b0, {tag, " R8 single strobe"}, int'(victim_valid), 0);
    chk(int'(victim_idx) == exp_v, {tag, " R8 idx held"}, int'(victim_idx), exp_v);
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int f = 0; f < NF; f++) begin
      m_hist[f] = '0;
      m_ref[f]  = 0;
    end
    m_tcnt = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R12 busy reset", int'(busy), 0);
    chk(victim_valid === 1'b0, "R12 valid reset", int'(victim_valid), 0);
    chk(victim_idx === '0, "R12 idx reset", int'(victim_idx), 0);
    rst_n = 1'b1;

    // R12/R7: all-zero histories tie, lowest index wins
    ask(0, 0, "R12 R7 fresh recency");
    ask(1, 0, "R7 fresh frequency");

    // R1/R4: reference all but frames 5 and 7; one tick alone ages nothing
    for (int f = 0; f < NF; f++) if (f != 5 && f != 7) ref_frame(f);
    cyc(0, 0, 0, 0, 1, 0, 0);
    ask(0, 0, "R4 no aging before interval");
    cyc(0, 0, 0, 0, 1, 0, 0);
    ask(0, 0, "R1 R2 R4 aged once");

    // R10: reference frame 5 on the aging cycle; R3: flags cleared afterwards
    ref_frame(7);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(1, 5, 0, 0, 1, 0, 0);
    ask(0, 0, "R10 same-cycle reference");
    age_once();
    ask(0, 0, "R3 R2 flag cleared then shifted");
    ask(1, 0, "R6 frequency after shifts");

    // R11: load clears a frame, and beats a same-cycle reference
    ref_frame(2);
    cyc(1, 3, 1, 3, 0, 0, 0);
    cyc(0, 0, 1, 2, 0, 0, 0);
    age_once();
    ask(0, 0, "R11 load clears");
    ask(1, 0, "R11 R6 load clears frequency");

    // R9: requests during the scan, with traffic, are ignored
    ask(0, 1, "R9 busy requests recency");
    ask(1, 1, "R9 busy requests frequency");

    // R5/R6: random traffic between requests
    for (int it = 0; it < 40; it++) begin
      int n = $urandom_range(30, 5);
      for (int j = 0; j < n; j++)
        cyc($urandom_range(2, 0) != 0, $urandom_range(NF-1, 0),
            $urandom_range(15, 0) == 0, $urandom_range(NF-1, 0),
            $urandom_range(1, 0) == 1, 0, 0);
      ask(it[0], it[1], it[0] ? "R6 random frequency" : "R5 random recency");
    end

    summary();
  end
endmodule